// File: doc/BRIEF.md
# Bus-Mapped Serial Transceiver with Status Flags

This block is an asynchronous serial transceiver controlled through a simple 32-bit register port. Software sets a bit-period divisor and control bits, writes bytes into a transmit holding register and reads received bytes from a receive register. The block sends each byte as an 8N1 frame on its serial output: one start bit, eight data bits with the least significant bit first, and one stop bit. It rebuilds frames arriving on its serial input into bytes.

A status word reports four things: transmit holding register empty, receive byte pending, receive overrun, and acknowledges that follow the transmitter and receiver enables. A single level interrupt output combines the receive-pending and transmit-empty conditions. Each of these two sources has its own enable bit. An overrun either keeps the unread byte and raises a sticky flag, or lets the new byte replace the old one, depending on a control bit.

The bus side has no wait states. A cycle with `bus_sel` high is one access: a write when `bus_wr` is high, otherwise a read. Read data is valid combinationally during that cycle. Read side effects take place at the closing clock edge.

Top module: `usart_mm`

## Requirements
- R1: After reset the status word (offset 0x1C) reads 0x00000080, meaning only the transmit-empty bit 7 is set. The control word (0x00) reads 0, `irq_o` is 0 and `txd_o` is 1.
- R2: The transmit register (0x28) keeps only the low 9 bits of a write. Writing 0xFFFFFFFF and reading it back returns 0x000001FF.
- R3: The control word at 0x00 holds the global enable (bit 0), receiver enable (bit 2), transmitter enable (bit 3), receive interrupt enable (bit 5) and transmit interrupt enable (bit 7). All its other bits read 0. Bit 12 of the word at 0x08 is the overrun-disable control. The divisor at 0x0C keeps 16 bits. Offsets 0x04, 0x10, 0x14 and 0x18 read 0.
- R4: Status bit 21 (transmit acknowledge) equals global enable AND transmitter enable. Status bit 22 (receive acknowledge) equals global enable AND receiver enable. Both become visible from the second cycle after the control write.
- R5: A valid 8N1 frame received while the global and receiver enables are set stores the byte, readable at 0x24 in bits 7:0, and sets status bit 5. Reading 0x24 clears bit 5.
- R6: `irq_o` is 1 exactly when (status bit 5 AND control bit 5) OR (status bit 7 AND control bit 7).
- R7: A write to 0x28 clears status bit 7. When the global and transmitter enables are set and the shifter is idle, the byte moves to the shifter and status bit 7 is set again two cycles after the write. `txd_o` then carries the frame: start 0, data LSB first, stop 1. `txd_o` is 1 whenever no frame is being sent.
- R8: If a frame completes while status bit 5 is still 1 and the overrun-disable bit is 0, status bit 3 (overrun) is set and 0x24 keeps the older byte. Writing 1 to bit 3 of 0x20 clears status bit 3.
- R9: With the overrun-disable bit set, a frame that completes while status bit 5 is 1 replaces the stored byte and leaves status bit 3 at 0.
- R10: A frame whose stop bit samples as 0 is discarded: status bit 5 stays 0.
- R11: One bit lasts exactly the divisor value in clock cycles. A divisor below 16 acts as 16. The receiver detects the start bit on a falling edge and samples each bit at its middle.
- R12: Frames that arrive while the global or receiver enable is 0 are ignored. While the transmitter is disabled, a written byte is held, status bit 7 stays 0 and `txd_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rxd_i | input | 1 | Serial input, idle high |
| txd_o | output | 1 | Serial output, idle high |
| irq_o | output | 1 | Level interrupt request |

## Verification
The flags are the part most likely to be wrong.

A receive-pending flag that is stuck or cleared at the wrong time shows on the interrupt pin in the same cycle. It also shows on the next status read. A wrong overrun decision shows up at the next read of the receive register, which returns the older byte or the newer one. A transmit-empty flag that fails to return is visible two cycles after the write to the transmit register. A divisor that is off by one shifts the start bit length on `txd_o` by whole cycles, and it corrupts a received byte within a single frame.

// File: rtl/usart_mm_pkg.sv
package usart_mm_pkg;
  // register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CTRL2 = 'h04;
  localparam int OFS_CTRL3 = 'h08;
  localparam int OFS_DIV   = 'h0C;
  localparam int OFS_STAT  = 'h1C;
  localparam int OFS_CLR   = 'h20;
  localparam int OFS_RXD   = 'h24;
  localparam int OFS_TXD   = 'h28;

  // control word bits
  localparam int CB_EN   = 0;
  localparam int CB_RXEN = 2;
  localparam int CB_TXEN = 3;
  localparam int CB_RXIE = 5;
  localparam int CB_TXIE = 7;
  localparam int XB_OVRDIS = 12;

  // status word bits
  localparam int SB_OVR  = 3;
  localparam int SB_RXF  = 5;
  localparam int SB_TXE  = 7;
  localparam int SB_TACK = 21;
  localparam int SB_RACK = 22;
  localparam int CLR_OVR = 3;

  localparam int DATA_BITS = 8;
  localparam int TXD_KEEP  = 9;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic {TX_IDLE, TX_SHIFT} tx_state_e;
endpackage

// File: rtl/usart_sync.sv
module usart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_mm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic [DIV_W-1:0]     div_i,
  output logic                 busy_o,
  output logic                 line_o
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int BIT_W = $clog2(FRAME_BITS);

  tx_state_e             state_q, state_d;
  logic [DIV_W-1:0]      cnt_q, cnt_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    case (state_q)
      TX_IDLE: begin
        if (load_i) begin
          sh_d    = {1'b1, data_i, 1'b0};
          cnt_d   = div_i - DIV_W'(1);
          bit_d   = '0;
          state_d = TX_SHIFT;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          if (bit_q == BIT_W'(FRAME_BITS-1)) begin
            state_d = TX_IDLE;
          end else begin
            sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
            bit_d = bit_q + BIT_W'(1);
            cnt_d = div_i - DIV_W'(1);
          end
        end else begin
          cnt_d = cnt_q - DIV_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign busy_o = (state_q == TX_SHIFT);
  assign line_o = busy_o ? sh_q[0] : 1'b1;
endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_mm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 rx_i,
  input  logic [DIV_W-1:0]     div_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int IDX_W = $clog2(DATA_BITS);

  rx_state_e            state_q, state_d;
  logic [DIV_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 prev_q, done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    done_d  = 1'b0;
    if (!en_i) begin
      state_d = RX_IDLE;
    end else begin
      case (state_q)
        RX_IDLE: begin
          if (prev_q && !rx_i) begin
            cnt_d   = (div_i >> 1) - DIV_W'(1);
            state_d = RX_START;
          end
        end
        RX_START: begin
          if (cnt_q == '0) begin
            if (!rx_i) begin
              cnt_d   = div_i - DIV_W'(1);
              idx_d   = '0;
              state_d = RX_DATA;
            end else begin
              state_d = RX_IDLE;
            end
          end else cnt_d = cnt_q - DIV_W'(1);
        end
        RX_DATA: begin
          if (cnt_q == '0) begin
            sh_d  = {rx_i, sh_q[DATA_BITS-1:1]};
            cnt_d = div_i - DIV_W'(1);
            idx_d = idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(DATA_BITS-1)) state_d = RX_STOP;
          end else cnt_d = cnt_q - DIV_W'(1);
        end
        default: begin
          if (cnt_q == '0) begin
            done_d  = rx_i;
            state_d = RX_IDLE;
          end else cnt_d = cnt_q - DIV_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      prev_q  <= rx_i;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;
endmodule

// File: rtl/usart_mm.sv
module usart_mm
  import usart_mm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CTRL3 = ADDR_W'(OFS_CTRL3);
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFS_DIV);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(OFS_RXD);
  localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(OFS_TXD);
  localparam logic [DIV_W-1:0]  DIV_MIN = DIV_W'(16);

  logic en_q, rxen_q, txen_q, rxie_q, txie_q, ovrdis_q;
  logic en_d, rxen_d, txen_d, rxie_d, txie_d, ovrdis_d;
  logic txe_q, rxne_q, ore_q, tack_q, rack_q;
  logic txe_d, rxne_d, ore_d, tack_d, rack_d;
  logic [DIV_W-1:0]     div_q, div_d, div_eff;
  logic [TXD_KEEP-1:0]  txd_q, txd_d;
  logic [DATA_BITS-1:0] rdr_q, rdr_d, rx_byte;
  logic acc_rd, acc_wr, rd_rxd, tx_load, tx_busy, rx_done, rx_line;
  logic unused_wdata;

  assign acc_rd  = bus_sel & ~bus_wr;
  assign acc_wr  = bus_sel & bus_wr;
  assign rd_rxd  = acc_rd & (bus_addr == A_RXD);
  assign div_eff = (div_q < DIV_MIN) ? DIV_MIN : div_q;
  assign tx_load = ~txe_q & ~tx_busy & en_q & txen_q;
  assign unused_wdata = ^bus_wdata[31:16];

  usart_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rx_line)
  );

  usart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(en_q & rxen_q), .rx_i(rx_line),
    .div_i(div_eff), .done_o(rx_done), .data_o(rx_byte)
  );

  usart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(tx_load), .data_i(txd_q[DATA_BITS-1:0]),
    .div_i(div_eff), .busy_o(tx_busy), .line_o(txd_o)
  );

  always_comb begin
    en_d = en_q;  rxen_d = rxen_q;  txen_d = txen_q;
    rxie_d = rxie_q;  txie_d = txie_q;  ovrdis_d = ovrdis_q;
    div_d = div_q;  txd_d = txd_q;  rdr_d = rdr_q;
    txe_d = txe_q;  rxne_d = rxne_q;  ore_d = ore_q;
    if (acc_wr) begin
      case (bus_addr)
        A_CTRL: begin
          en_d   = bus_wdata[CB_EN];
          rxen_d = bus_wdata[CB_RXEN];
          txen_d = bus_wdata[CB_TXEN];
          rxie_d = bus_wdata[CB_RXIE];
          txie_d = bus_wdata[CB_TXIE];
        end
        A_CTRL3: ovrdis_d = bus_wdata[XB_OVRDIS];
        A_DIV:   div_d = bus_wdata[DIV_W-1:0];
        A_TXD:   txd_d = bus_wdata[TXD_KEEP-1:0];
        A_CLR:   if (bus_wdata[CLR_OVR]) ore_d = 1'b0;
        default: ;
      endcase
    end
    // transmit holding handshake: a new write wins over a hand-off
    if (tx_load) txe_d = 1'b1;
    if (acc_wr && (bus_addr == A_TXD)) txe_d = 1'b0;
    // receive side: the read is taken first, then a finished frame
    if (rd_rxd) rxne_d = 1'b0;
    if (rx_done) begin
      if (rxne_q && !ovrdis_q && !rd_rxd) begin
        ore_d = 1'b1;
      end else begin
        rdr_d  = rx_byte;
        rxne_d = 1'b1;
      end
    end
    tack_d = en_q & txen_q;
    rack_d = en_q & rxen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;  rxen_q <= 1'b0;  txen_q <= 1'b0;
      rxie_q <= 1'b0;  txie_q <= 1'b0;  ovrdis_q <= 1'b0;
      div_q <= '0;  txd_q <= '0;  rdr_q <= '0;
      txe_q <= 1'b1;  rxne_q <= 1'b0;  ore_q <= 1'b0;
      tack_q <= 1'b0;  rack_q <= 1'b0;
    end else begin
      en_q <= en_d;  rxen_q <= rxen_d;  txen_q <= txen_d;
      rxie_q <= rxie_d;  txie_q <= txie_d;  ovrdis_q <= ovrdis_d;
      div_q <= div_d;  txd_q <= txd_d;  rdr_q <= rdr_d;
      txe_q <= txe_d;  rxne_q <= rxne_d;  ore_q <= ore_d;
      tack_q <= tack_d;  rack_q <= rack_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      case (bus_addr)
        A_CTRL: begin
          bus_rdata[CB_EN]   = en_q;
          bus_rdata[CB_RXEN] = rxen_q;
          bus_rdata[CB_TXEN] = txen_q;
          bus_rdata[CB_RXIE] = rxie_q;
          bus_rdata[CB_TXIE] = txie_q;
        end
        A_CTRL3: bus_rdata[XB_OVRDIS] = ovrdis_q;
        A_DIV:   bus_rdata = 32'(div_q);
        A_STAT: begin
          bus_rdata[SB_OVR]  = ore_q;
          bus_rdata[SB_RXF]  = rxne_q;
          bus_rdata[SB_TXE]  = txe_q;
          bus_rdata[SB_TACK] = tack_q;
          bus_rdata[SB_RACK] = rack_q;
        end
        A_RXD:   bus_rdata = 32'(rdr_q);
        A_TXD:   bus_rdata = 32'(txd_q);
        default: ;
      endcase
    end
  end

  assign irq_o = (rxne_q & rxie_q) | (txe_q & txie_q);
endmodule

// File: rtl/usart_mm_chk.sv
module usart_mm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxne,
  input logic       ore,
  input logic       ovrdis,
  input logic       rd_rxd,
  input logic [7:0] rdr,
  input logic       txe,
  input logic       tx_load,
  input logic       txen_eff,
  input logic       tack,
  input logic       irq,
  input logic       tx_busy,
  input logic       txd
);
  // R8
  ore_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ore) |-> ($past(rxne) && !$past(ovrdis)));

  // R8
  rdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxne && !ovrdis && !rd_rxd) |=> $stable(rdr));

  // R7
  txe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txe) |-> $past(tx_load));

  // R4
  tack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txen_eff |=> !tack);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rxne || txe));

  // R7
  line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
endmodule

bind usart_mm usart_mm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxne(rxne_q), .ore(ore_q), .ovrdis(ovrdis_q),
  .rd_rxd(rd_rxd), .rdr(rdr_q), .txe(txe_q), .tx_load(tx_load),
  .txen_eff(en_q & txen_q), .tack(tack_q), .irq(irq_o),
  .tx_busy(tx_busy), .txd(txd_o)
);

// File: tb/usart_mm_tb.sv
module usart_mm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_CTRL = 'h00, T_CTRL2 = 'h04, T_CTRL3 = 'h08, T_DIV = 'h0C;
  localparam int T_GAP1 = 'h10, T_GAP2 = 'h14, T_GAP3 = 'h18;
  localparam int T_STAT = 'h1C, T_CLR = 'h20, T_RXD = 'h24, T_TXD = 'h28;

  logic clk, rst_n, bus_sel, bus_wr, rxd_i, txd_o, irq_o;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] rd;

  usart_mm u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd_i(rxd_i), .txd_o(txd_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; rxd_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_bit, input int div);
    @(negedge clk) rxd_i = 1'b0;
    repeat (div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i];
      repeat (div) @(negedge clk);
    end
    rxd_i = stop_bit;
    repeat (div) @(negedge clk);
    rxd_i = 1'b1;
    repeat (div) @(negedge clk);
  endtask

  task automatic grab_frame(input int div, output logic [7:0] b, output logic stop_bit);
    @(negedge clk);
    while (txd_o !== 1'b0) @(negedge clk);
    repeat (div/2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (div) @(negedge clk);
      b[i] = txd_o;
    end
    repeat (div) @(negedge clk);
    stop_bit = txd_o;
  endtask

  task automatic t_reset();
    do_reset();
    bus_read(T_STAT, rd); chk("R1 status", rd, 32'h80);
    bus_read(T_CTRL, rd); chk("R1 ctrl", rd, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 txd", {31'b0, txd_o}, 32'h1);
  endtask

  task automatic t_regs();
    do_reset();
    bus_write(T_TXD, 32'hFFFFFFFF);
    bus_read(T_TXD, rd); chk("R2 txd mask", rd, 32'h1FF);
    bus_write(T_CTRL, 32'hFFFFFFFF);
    bus_read(T_CTRL, rd); chk("R3 ctrl bits", rd, 32'hAD);
    bus_write(T_CTRL3, 32'hFFFFFFFF);
    bus_read(T_CTRL3, rd); chk("R3 ctrl3 bit", rd, 32'h1000);
    bus_write(T_DIV, 32'hFFFF1234);
    bus_read(T_DIV, rd); chk("R3 div", rd, 32'h1234);
    bus_read(T_CTRL2, rd); chk("R3 gap 0x04", rd, 32'h0);
    bus_read(T_GAP1, rd); chk("R3 gap 0x10", rd, 32'h0);
    bus_read(T_GAP2, rd); chk("R3 gap 0x14", rd, 32'h0);
    bus_read(T_GAP3, rd); chk("R3 gap 0x18", rd, 32'h0);
  endtask

  task automatic t_ack();
    do_reset();
    bus_write(T_CTRL, 32'h0D);
    @(posedge clk);
    bus_read(T_STAT, rd); chk("R4 acks set", rd & 32'h0060_0000, 32'h0060_0000);
    bus_write(T_CTRL, 32'h01);
    @(posedge clk);
    bus_read(T_STAT, rd); chk("R4 acks clear", rd & 32'h0060_0000, 32'h0);
    bus_write(T_CTRL, 32'h08);
    @(posedge clk);
    bus_read(T_STAT, rd); chk("R4 tx ack needs global enable", rd & 32'h0060_0000, 32'h0);
  endtask

  task automatic t_rx();
    do_reset();
    bus_write(T_DIV, 16);
    bus_write(T_CTRL, 32'h05);
    send_frame(8'hA5, 1'b1, 16);
    bus_read(T_STAT, rd); chk("R5 rx flag", rd & 32'h20, 32'h20);
    chk("R6 irq masked", {31'b0, irq_o}, 32'h0);
    bus_write(T_CTRL, 32'h25);
    @(negedge clk);
    chk("R6 irq rx", {31'b0, irq_o}, 32'h1);
    bus_read(T_RXD, rd); chk("R5 rx byte", rd, 32'hA5);
    bus_read(T_STAT, rd); chk("R5 rx flag cleared", rd & 32'h20, 32'h0);
    chk("R6 irq drops", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_tx();
    logic [7:0] b; logic sb;
    do_reset();
    bus_write(T_DIV, 16);
    bus_write(T_CTRL, 32'h89);
    @(negedge clk);
    chk("R6 irq tx empty", {31'b0, irq_o}, 32'h1);
    bus_write(T_TXD, 32'h3C);
    #1 chk("R6 irq after write", {31'b0, irq_o}, 32'h0);
    bus_read(T_STAT, rd); chk("R7 txe cleared", rd & 32'h80, 32'h0);
    grab_frame(16, b, sb);
    chk("R7 tx byte", {24'b0, b}, 32'h3C);
    chk("R7 tx stop", {31'b0, sb}, 32'h1);
    bus_read(T_STAT, rd); chk("R7 txe back", rd & 32'h80, 32'h80);
    chk("R6 irq tx back", {31'b0, irq_o}, 32'h1);
    repeat (32) @(negedge clk);
  endtask

  task automatic t_baud(input int div, input int expect_len);
    int low = 0;
    logic [7:0] b; logic sb;
    do_reset();
    bus_write(T_DIV, 32'(div));
    bus_write(T_CTRL, 32'h0D);
    bus_write(T_TXD, 32'h01);
    @(negedge clk);
    while (txd_o !== 1'b0) @(negedge clk);
    while (txd_o === 1'b0) begin low++; @(negedge clk); end
    chk("R11 start bit length", 32'(low), 32'(expect_len));
    repeat (12 * expect_len) @(negedge clk);
    bus_write(T_TXD, 32'hC3);
    grab_frame(expect_len, b, sb);
    chk("R11 tx byte at divisor", {24'b0, b}, 32'hC3);
    repeat (2 * expect_len) @(negedge clk);
    send_frame(8'h5A, 1'b1, expect_len);
    bus_read(T_RXD, rd); chk("R11 rx byte at divisor", rd, 32'h5A);
  endtask

  task automatic t_overrun();
    do_reset();
    bus_write(T_DIV, 16);
    bus_write(T_CTRL, 32'h05);
    send_frame(8'h11, 1'b1, 16);
    send_frame(8'h22, 1'b1, 16);
    bus_read(T_STAT, rd); chk("R8 overrun flag", rd & 32'h28, 32'h28);
    bus_read(T_RXD, rd); chk("R8 old byte kept", rd, 32'h11);
    bus_write(T_CLR, 32'h08);
    bus_read(T_STAT, rd); chk("R8 overrun cleared", rd & 32'h08, 32'h0);
  endtask

  task automatic t_ovrdis();
    do_reset();
    bus_write(T_DIV, 16);
    bus_write(T_CTRL3, 32'h1000);
    bus_write(T_CTRL, 32'h05);
    send_frame(8'h33, 1'b1, 16);
    send_frame(8'h44, 1'b1, 16);
    bus_read(T_STAT, rd); chk("R9 no overrun", rd & 32'h28, 32'h20);
    bus_read(T_RXD, rd); chk("R9 new byte", rd, 32'h44);
  endtask

  task automatic t_frame();
    do_reset();
    bus_write(T_DIV, 16);
    bus_write(T_CTRL, 32'h05);
    send_frame(8'h77, 1'b0, 16);
    repeat (32) @(negedge clk);
    bus_read(T_STAT, rd); chk("R10 bad stop dropped", rd & 32'h20, 32'h0);
  endtask

  task automatic t_disabled();
    int lows = 0;
    do_reset();
    bus_write(T_DIV, 16);
    bus_write(T_CTRL, 32'h04);
    send_frame(8'h99, 1'b1, 16);
    bus_read(T_STAT, rd); chk("R12 rx ignored without global enable", rd & 32'h20, 32'h0);
    bus_write(T_CTRL, 32'h01);
    send_frame(8'h99, 1'b1, 16);
    bus_read(T_STAT, rd); chk("R12 rx ignored without rx enable", rd & 32'h20, 32'h0);
    bus_write(T_TXD, 32'h55);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (txd_o !== 1'b1) lows++;
    end
    chk("R12 line idle with tx off", 32'(lows), 32'h0);
    bus_read(T_STAT, rd); chk("R12 byte held", rd & 32'h80, 32'h0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_ack();
    t_rx();
    t_tx();
    t_baud(16, 16);
    t_baud(40, 40);
    t_baud(5, 16);
    t_overrun();
    t_ovrdis();
    t_frame();
    t_disabled();
    summary();
  end
endmodule